// File: doc/BRIEF.md
# Pipelined Bit-Pair Unsigned Multiplier

This block multiplies two unsigned operands and returns the exact double-width product. It splits the multiplier operand into 2-bit groups. For each group it selects zero, one, two or three times the multiplicand. The triple multiple is the multiplicand plus the multiplicand shifted left by one place. Each selected multiple is moved left by twice its group index. The shifted terms are then summed in a tree of registered two-input adders.

The block is fully pipelined and accepts a new operand pair on every clock. A qualifier bit travels with each pair, so the consumer knows which output cycles carry a result. With the default 12-bit operands there are six groups, and the tree reduces them in three registered levels (six to three, three to two, two to one). An input register and an output register complete a fixed five-cycle path. Pipeline stages load only when the pair they hold is qualified. Between results the output holds the most recent product.

Top module: `pairmul_top`

## Requirements
- R1: For every pair of OP_W-bit unsigned operands (default 12), `product_o` equals the exact 2*OP_W-bit product. No bits are dropped or rounded, and any operand value is allowed.
- R2: A pair sampled with `valid_i` high on a rising edge produces `valid_o` high in the cycle after the fifth rising edge from that one. That is a latency of 5 clocks.
- R3: Pairs presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R4: `valid_o` is low in every cycle whose corresponding input cycle, 5 clocks earlier, had `valid_i` low.
- R5: While `valid_o` is low, `product_o` keeps its last value. Operand values presented with `valid_i` low have no effect on `product_o`.
- R6: While `rst_ni` is low, `valid_o` and `product_o` are 0. A pair accepted before a reset does not emerge after the reset.
- R7: The extreme operands give exact results: all-ones times all-ones gives 0xFFE001 for 12 bits, and zero times any value gives 0.
- R8: Every group value works. Group code 2'b00 selects 0, 2'b01 selects 1x, 2'b10 selects 2x and 2'b11 selects 3x the multiplicand. Group g is taken from multiplier bits [2g+1:2g] and is weighted by 4^g.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand pair qualifier |
| a_i | input | OP_W | Multiplicand |
| b_i | input | OP_W | Multiplier, split into bit pairs |
| valid_o | output | 1 | Result qualifier, 5 cycles after `valid_i` |
| product_o | output | 2*OP_W | Full unsigned product |

## Verification
A wrong multiple for one bit-pair code, or a wrong shift for one group, shows up as a wrong product on the fifth cycle after the pair enters. Such a fault only appears for multipliers that contain that code in that group. The vector set therefore includes multipliers made entirely of 01, 10 or 11 pairs, together with the extreme operands. A missing or extra register in the qualifier path or the data path moves `valid_o` or the product by a whole cycle. Back-to-back and gapped streams expose that as a mismatch in the first cycle checked. A stage that loads while unqualified alters `product_o` during an idle cycle.

// File: rtl/pairmul_pkg.sv
package pairmul_pkg;
  // bit-pair code -> multiple of the multiplicand
  typedef enum logic [1:0] {
    SEL_ZERO  = 2'b00,
    SEL_ONE   = 2'b01,
    SEL_TWO   = 2'b10,
    SEL_THREE = 2'b11
  } pair_sel_e;

  localparam int unsigned PAIR_W = 2;
endpackage

// File: rtl/pairmul_ppgen.sv
module pairmul_ppgen
  import pairmul_pkg::*;
#(
  parameter int unsigned OP_W   = 12,
  parameter int unsigned N_GRP  = 6,
  parameter int unsigned PROD_W = 24,
  localparam int unsigned MP_W  = PAIR_W * N_GRP
) (
  input  logic [OP_W-1:0]                 mcand_i,
  input  logic [MP_W-1:0]                 mplier_i,
  output logic [N_GRP-1:0][PROD_W-1:0]    pp_o
);

  logic [PROD_W-1:0] mul1, mul2, mul3;

  assign mul1 = PROD_W'(mcand_i);
  assign mul2 = mul1 << 1;
  assign mul3 = mul1 + mul2;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    pair_sel_e         sel;
    logic [PROD_W-1:0] mult;

    assign sel = pair_sel_e'(mplier_i[PAIR_W*g +: PAIR_W]);

    always_comb begin
      unique case (sel)
        SEL_ZERO:  mult = '0;
        SEL_ONE:   mult = mul1;
        SEL_TWO:   mult = mul2;
        SEL_THREE: mult = mul3;
        default:   mult = '0;
      endcase
    end

    assign pp_o[g] = mult << (PAIR_W * g);
  end

endmodule

// File: rtl/pairmul_tree_level.sv
module pairmul_tree_level #(
  parameter int unsigned N_IN  = 6,
  parameter int unsigned W     = 24,
  localparam int unsigned N_OUT = (N_IN + 1) / 2,
  localparam int unsigned N_PAIR = N_IN / 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         vld_i,
  input  logic [N_IN-1:0][W-1:0]       d_i,
  output logic                         vld_o,
  output logic [N_OUT-1:0][W-1:0]      q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  for (genvar j = 0; j < N_PAIR; j++) begin : g_add
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[j] <= '0;
      else if (vld_i) q_o[j] <= d_i[2*j] + d_i[2*j+1];
    end
  end

  // odd count: last term passes through one stage
  if (N_IN % 2 == 1) begin : g_odd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[N_OUT-1] <= '0;
      else if (vld_i) q_o[N_OUT-1] <= d_i[N_IN-1];
    end
  end

endmodule

// File: rtl/pairmul_top.sv
module pairmul_top
  import pairmul_pkg::*;
#(
  parameter int unsigned OP_W = 12  // 9..16: tree depth fixed at three levels
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [OP_W-1:0]     a_i,
  input  logic [OP_W-1:0]     b_i,
  output logic                valid_o,
  output logic [2*OP_W-1:0]   product_o
);

  localparam int unsigned N_GRP  = (OP_W + 1) / 2;
  localparam int unsigned MP_W   = PAIR_W * N_GRP;
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned N_L1   = (N_GRP + 1) / 2;
  localparam int unsigned N_L2   = (N_L1 + 1) / 2;
  localparam int unsigned N_L3   = (N_L2 + 1) / 2;

  // stage 1: operand capture
  logic [OP_W-1:0] a_q;
  logic [MP_W-1:0] b_q;
  logic            v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        a_q <= a_i;
        b_q <= MP_W'(b_i);
      end
    end
  end

  logic [N_GRP-1:0][PROD_W-1:0] pp;

  pairmul_ppgen #(
    .OP_W   (OP_W),
    .N_GRP  (N_GRP),
    .PROD_W (PROD_W)
  ) ppgen_i (
    .mcand_i  (a_q),
    .mplier_i (b_q),
    .pp_o     (pp)
  );

  // stages 2..4: registered reduction
  logic [N_L1-1:0][PROD_W-1:0] l1_q;
  logic [N_L2-1:0][PROD_W-1:0] l2_q;
  logic [N_L3-1:0][PROD_W-1:0] l3_q;
  logic                        l1_v, l2_v, l3_v;

  pairmul_tree_level #(.N_IN(N_GRP), .W(PROD_W)) lvl1_i (
    .clk_i, .rst_ni, .vld_i(v_q),  .d_i(pp),   .vld_o(l1_v), .q_o(l1_q)
  );

  pairmul_tree_level #(.N_IN(N_L1), .W(PROD_W)) lvl2_i (
    .clk_i, .rst_ni, .vld_i(l1_v), .d_i(l1_q), .vld_o(l2_v), .q_o(l2_q)
  );

  pairmul_tree_level #(.N_IN(N_L2), .W(PROD_W)) lvl3_i (
    .clk_i, .rst_ni, .vld_i(l2_v), .d_i(l2_q), .vld_o(l3_v), .q_o(l3_q)
  );

  // stage 5: output register, holds between results
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      product_o <= '0;
    end else begin
      valid_o <= l3_v;
      if (l3_v) product_o <= l3_q[0];
    end
  end

endmodule

// File: rtl/pairmul_chk.sv
module pairmul_chk #(
  parameter int unsigned OP_W   = 12,
  parameter int unsigned PROD_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic              valid_o,
  input logic [PROD_W-1:0] product_o
);

  logic [2:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst < 3'd5) since_rst <= since_rst + 3'd1;
  end

  // R2 R4
  lat_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 3'd5) |-> (valid_o == $past(valid_i, 5)));

  // R1
  prod_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 3'd5 && valid_o) |->
      (product_o == (PROD_W'($past(a_i, 5)) * PROD_W'($past(b_i, 5)))));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(product_o));

  // R6
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && product_o == '0));

endmodule

bind pairmul_top pairmul_chk #(.OP_W(OP_W), .PROD_W(2*OP_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .valid_o   (valid_o),
  .product_o (product_o)
);

// File: tb/pairmul_top_tb_top.sv
module pairmul_top_tb_top;

  typedef struct packed {
    logic [11:0] a;
    logic [11:0] b;
    logic [23:0] p;
  } vec_t;

  localparam int N_VEC = 12;
  localparam vec_t VEC [N_VEC] = '{
    '{12'd0,    12'd0,    24'd0},         // R7 zero
    '{12'd4095, 12'd4095, 24'd16769025},  // R7 max*max
    '{12'd4095, 12'd1,    24'd4095},
    '{12'd1,    12'd4095, 24'd4095},      // R8 all 11 pairs
    '{12'd4095, 12'd2730, 24'd11179350},  // R8 all 10 pairs
    '{12'd4095, 12'd1365, 24'd5589675},   // R8 all 01 pairs
    '{12'd2048, 12'd2048, 24'd4194304},
    '{12'd3,    12'd3,    24'd9},
    '{12'd1234, 12'd567,  24'd699678},
    '{12'd2730, 12'd1365, 24'd3726450},
    '{12'd100,  12'd4095, 24'd409500},
    '{12'd4095, 12'd2,    24'd8190}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        valid_i = 1'b0;
  logic [11:0] a_i = '0;
  logic [11:0] b_i = '0;
  logic        valid_o;
  logic [23:0] product_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pairmul_top #(.OP_W(12)) dut_i (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i, .valid_o, .product_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input bit v, input logic [11:0] a, input logic [11:0] b);
    valid_i = v;
    a_i     = a;
    b_i     = b;
  endtask

  initial begin
    logic [23:0] last_p;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R6 reset state
    chk(valid_o == 1'b0, "R6 valid in reset", 32'(valid_o), 0);
    chk(product_o == 24'd0, "R6 product in reset", 32'(product_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R3 R4 R7 R8: back-to-back stream of table vectors
    for (int c = 0; c < N_VEC + 5; c++) begin
      if (c < 5) begin
        chk(valid_o == 1'b0, "R4 idle before stream", 32'(valid_o), 0);
      end else begin
        chk(valid_o == 1'b1, "R3 stream valid", 32'(valid_o), 1);
        chk(product_o == VEC[c-5].p, "R1 stream product", 32'(product_o),
            32'(VEC[c-5].p));
        chk(32'(VEC[c-5].a) * 32'(VEC[c-5].b) == 32'(VEC[c-5].p),
            "R1 table self", 32'(VEC[c-5].p), 32'(VEC[c-5].a) * 32'(VEC[c-5].b));
      end
      if (c < N_VEC) drive(1'b1, VEC[c].a, VEC[c].b);
      else           drive(1'b0, 12'hABC, 12'h123);
      @(negedge clk_i);
    end
    last_p = VEC[N_VEC-1].p;

    // R5: unqualified operands ignored, output held
    for (int c = 0; c < 8; c++) begin
      drive(1'b0, 12'(c * 511), 12'(4095 - c * 97));
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R5 idle valid", 32'(valid_o), 0);
      chk(product_o == last_p, "R5 hold product", 32'(product_o), 32'(last_p));
    end

    // R2: single pulse, valid exactly 5 cycles later
    drive(1'b1, 12'd7, 12'd9);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk_i);
      drive(1'b0, 12'd0, 12'd0);
      chk(valid_o == (k == 5), "R2 latency", 32'(valid_o), 32'(k == 5));
      if (k >= 5) chk(product_o == 24'd63, "R2 product", 32'(product_o), 63);
    end

    // R3 R4: gapped pattern 1,0,1,1,0,1
    begin
      bit          pat [6] = '{1, 0, 1, 1, 0, 1};
      logic [11:0] pa  [6] = '{12'd11, 12'd99, 12'd4000, 12'd17, 12'd5, 12'd255};
      logic [11:0] pb  [6] = '{12'd13, 12'd98, 12'd3, 12'd4095, 12'd6, 12'd255};
      logic [23:0] hold_p;
      hold_p = 24'd63;
      for (int c = 0; c < 11; c++) begin
        if (c >= 5) begin
          chk(valid_o == pat[c-5], "R4 gap valid", 32'(valid_o), 32'(pat[c-5]));
          if (pat[c-5]) hold_p = 24'(32'(pa[c-5]) * 32'(pb[c-5]));
          chk(product_o == hold_p, "R3 gap product", 32'(product_o), 32'(hold_p));
        end
        if (c < 6) drive(pat[c], pa[c], pb[c]);
        else       drive(1'b0, 12'd0, 12'd0);
        @(negedge clk_i);
      end
    end

    // R6: reset while a pair is in flight
    drive(1'b1, 12'd5, 12'd5);
    @(negedge clk_i);
    drive(1'b0, 12'd0, 12'd0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R6 mid reset valid", 32'(valid_o), 0);
    chk(product_o == 24'd0, "R6 mid reset product", 32'(product_o), 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R6 flushed pair", 32'(valid_o), 0);
      chk(product_o == 24'd0, "R6 product after reset", 32'(product_o), 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule